// File: doc/BRIEF.md
# Serial ADC Frame Interface Controller

This block is the converter-side digital control of a 12-bit serial sampling ADC. A host drives an active-low chip select, a frame-sync strobe and a serial clock. The block opens a 16-clock frame, shifts the result of the previous conversion out MSB first on a serial data pin with a separate output enable, marks the acquisition window, and then runs a conversion timed by further serial clocks. The analog sampler and the SAR core are outside the block. The conversion result arrives as a 12-bit input word and is latched when the modelled conversion time has elapsed.

All three host pins are asynchronous. They are brought into the system clock domain through two-flop synchronizers, and every edge is detected there. A frame begins either on a chip-select falling edge while frame sync is high, or on a frame-sync falling edge while chip select is low. A chip-select rising edge before the conversion finishes aborts it. The next frame then carries an all-zero word in place of a result. The block sleeps after each conversion or abort and wakes at the next frame start.

Top module: `adc_serial_frame`

## Requirements
- R1: After reset, sdo_oe, sample_win, conv_busy, conv_done and data_valid are 0 and pwr_down is 1.
- R2: A falling edge on cs_n while fs is high starts a frame. sdo_oe goes to 1, sdo_data shows frame bit 15, and pwr_down goes to 0.
- R3: A falling edge on cs_n while fs is low does not start a frame. A later falling edge on fs while cs_n is low does start one.
- R4: A frame word is 16 bits. Bits 15..4 hold the stored 12-bit result unchanged, in straight binary, most significant bit first. Bits 3..0 are 0. The bit on sdo_data advances on sclk rising edges 2..16, so the host reads frame bit 16-n at sclk falling edge n.
- R5: sdo_oe returns to 0 on the 17th sclk rising edge of a frame, or earlier on a cs_n rising edge.
- R6: sample_win rises at the 4th sclk falling edge and falls at the 16th. It is therefore high during clocks 5 to 16, which is 12 clocks.
- R7: conv_busy rises at the 16th sclk falling edge. On the 30th sclk falling edge after that, conv_busy falls, conv_result is latched, and conv_done and data_valid go to 1.
- R8: A latched result is sent in the next frame. A frame with no valid stored result, such as the first frame after reset, sends an all-zero word.
- R9: A cs_n rising edge during a frame or a conversion aborts it. conv_busy, conv_done and data_valid go to 0, and the next frame word is all zero. A cs_n rising edge after completion leaves data_valid at 1.
- R10: pwr_down goes to 1 at conversion completion or at an abort, and goes to 0 at a frame start.
- R11: Start edges that arrive while a frame or conversion is in progress are ignored. sdo_oe stays 0 and the running conversion completes on its normal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sclk |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous chip select, active low |
| fs | input | 1 | Asynchronous frame-sync strobe |
| sclk | input | 1 | Asynchronous host serial clock |
| conv_result | input | 12 | Converted code from the SAR core |
| sdo_data | output | 1 | Serial data bit, 0 while disabled |
| sdo_oe | output | 1 | Output enable for the serial data pin |
| sample_win | output | 1 | Acquisition window active |
| conv_busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | Last conversion completed |
| data_valid | output | 1 | Stored result is valid for the next frame |
| pwr_down | output | 1 | Block is in automatic power-down |

## Verification
A wrong falling-edge count in the frame sequencer shows up within a single sclk period, as a sample window that opens or closes on the wrong clock. A wrong count in the conversion counter shows up as conv_busy falling one clock early or late. A fault in the output shifter or in the result register stays hidden until the following frame, where the 16 captured bits differ from the word the bench predicted. A lost abort shows up in that same next frame as a non-zero word where all zeros were due. Start edges arriving during busy periods test that an unintended restart would raise sdo_oe while conversion is still running.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    // Index of each host pin in the synchronized vectors
    localparam int unsigned PIN_CS  = 0;
    localparam int unsigned PIN_FS  = 1;
    localparam int unsigned PIN_SCK = 2;
    localparam int unsigned PIN_CNT = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FRAME = 2'd1,
        SEQ_CONV  = 2'd2
    } seq_state_e;

    // One-cycle events produced by the sequencer
    typedef struct packed {
        logic frame_start;
        logic sclk_rise;
        logic cs_rise;
        logic conv_end;
        logic abort;
    } seq_evt_t;

    function automatic logic fell(input logic now, input logic prev);
        return prev & ~now;
    endfunction

    function automatic logic rose(input logic now, input logic prev);
        return ~prev & now;
    endfunction

endpackage

// File: rtl/adcf_sync.sv
module adcf_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prv
);

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        logic              prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain  <= {STAGES{RST_VAL[g]}};
                prev_q <= RST_VAL[g];
            end else begin
                chain  <= {chain[STAGES-2:0], din[g]};
                prev_q <= chain[STAGES-1];
            end
        end

        assign lvl[g] = chain[STAGES-1];
        assign prv[g] = prev_q;
    end

endmodule

// File: rtl/adcf_frame_seq.sv
module adcf_frame_seq
    import adcf_pkg::*;
#(
    parameter int unsigned FRAME_CLKS = 16,
    parameter int unsigned WIN_OPEN   = 4,
    parameter int unsigned CONV_SCLKS = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PIN_CNT-1:0] lvl,
    input  logic [PIN_CNT-1:0] prv,
    output seq_evt_t           evt,
    output logic               sample_win,
    output logic               conv_busy
);

    localparam int unsigned FCW = $clog2(FRAME_CLKS + 1);
    localparam int unsigned CCW = $clog2(CONV_SCLKS + 1);
    localparam logic [FCW-1:0] F_WIN_LAST = FCW'(WIN_OPEN - 1);
    localparam logic [FCW-1:0] F_END_LAST = FCW'(FRAME_CLKS - 1);
    localparam logic [CCW-1:0] C_LAST     = CCW'(CONV_SCLKS - 1);

    seq_state_e     state_q;
    logic [FCW-1:0] fcnt_q;
    logic [CCW-1:0] ccnt_q;
    logic           win_q;

    logic cs_fall, cs_rise, fs_fall, sck_fall, sck_rise;
    logic start, abort, conv_end;

    assign cs_fall  = fell(lvl[PIN_CS],  prv[PIN_CS]);
    assign cs_rise  = rose(lvl[PIN_CS],  prv[PIN_CS]);
    assign fs_fall  = fell(lvl[PIN_FS],  prv[PIN_FS]);
    assign sck_fall = fell(lvl[PIN_SCK], prv[PIN_SCK]);
    assign sck_rise = rose(lvl[PIN_SCK], prv[PIN_SCK]);

    // Frame start: CS fall with FS high, or FS fall with CS low
    assign start = (state_q == SEQ_IDLE) &&
                   ((cs_fall && lvl[PIN_FS]) || (fs_fall && !lvl[PIN_CS]));
    assign abort    = cs_rise && (state_q != SEQ_IDLE);
    assign conv_end = (state_q == SEQ_CONV) && !cs_rise && sck_fall &&
                      (ccnt_q == C_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            fcnt_q  <= '0;
            ccnt_q  <= '0;
            win_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_FRAME;
                        fcnt_q  <= '0;
                    end
                end
                SEQ_FRAME: begin
                    if (cs_rise) begin
                        state_q <= SEQ_IDLE;
                        win_q   <= 1'b0;
                    end else if (sck_fall) begin
                        fcnt_q <= fcnt_q + 1'b1;
                        if (fcnt_q == F_WIN_LAST) begin
                            win_q <= 1'b1;
                        end
                        if (fcnt_q == F_END_LAST) begin
                            win_q   <= 1'b0;
                            state_q <= SEQ_CONV;
                            ccnt_q  <= '0;
                        end
                    end
                end
                SEQ_CONV: begin
                    if (cs_rise || conv_end) begin
                        state_q <= SEQ_IDLE;
                    end else if (sck_fall) begin
                        ccnt_q <= ccnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        evt.frame_start = start;
        evt.sclk_rise   = sck_rise;
        evt.cs_rise     = cs_rise;
        evt.conv_end    = conv_end;
        evt.abort       = abort;
    end

    assign sample_win = win_q;
    assign conv_busy  = (state_q == SEQ_CONV);

endmodule

// File: rtl/adcf_sdo_shift.sv
module adcf_sdo_shift
    import adcf_pkg::*;
#(
    parameter int unsigned FRAME_CLKS = 16,
    parameter int unsigned RES_W      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_evt_t         evt,
    input  logic [RES_W-1:0] res_hold,
    input  logic             res_valid,
    output logic             sdo_oe,
    output logic             sdo_data
);

    localparam int unsigned PAD = FRAME_CLKS - RES_W;
    localparam int unsigned RCW = $clog2(FRAME_CLKS + 1);
    localparam logic [RCW-1:0] R_LAST = RCW'(FRAME_CLKS);

    logic [FRAME_CLKS-1:0] sh_q;
    logic [FRAME_CLKS-1:0] load_word;
    logic [RCW-1:0]        rcnt_q;
    logic                  oe_q;

    // Result left-justified, padding bits zero; invalid result sends zeros
    assign load_word = res_valid ? {res_hold, {PAD{1'b0}}} : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rcnt_q <= '0;
            oe_q   <= 1'b0;
        end else if (evt.frame_start) begin
            sh_q   <= load_word;
            rcnt_q <= '0;
            oe_q   <= 1'b1;
        end else if (evt.cs_rise) begin
            oe_q <= 1'b0;
        end else if (evt.sclk_rise && oe_q) begin
            if (rcnt_q == R_LAST) begin
                oe_q <= 1'b0;
            end else begin
                if (rcnt_q != '0) begin
                    sh_q <= {sh_q[FRAME_CLKS-2:0], 1'b0};
                end
                rcnt_q <= rcnt_q + 1'b1;
            end
        end
    end

    assign sdo_oe   = oe_q;
    assign sdo_data = oe_q & sh_q[FRAME_CLKS-1];

endmodule

// File: rtl/adcf_result_hold.sv
module adcf_result_hold
    import adcf_pkg::*;
#(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_evt_t         evt,
    input  logic [RES_W-1:0] conv_result,
    output logic [RES_W-1:0] res_hold,
    output logic             res_valid,
    output logic             conv_done,
    output logic             pwr_down
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_hold  <= '0;
            res_valid <= 1'b0;
            conv_done <= 1'b0;
            pwr_down  <= 1'b1;
        end else if (evt.conv_end) begin
            res_hold  <= conv_result;
            res_valid <= 1'b1;
            conv_done <= 1'b1;
            pwr_down  <= 1'b1;
        end else if (evt.abort) begin
            res_valid <= 1'b0;
            conv_done <= 1'b0;
            pwr_down  <= 1'b1;
        end else if (evt.frame_start) begin
            conv_done <= 1'b0;
            pwr_down  <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_serial_frame.sv
module adc_serial_frame
    import adcf_pkg::*;
#(
    parameter int unsigned RES_W       = 12,
    parameter int unsigned FRAME_CLKS  = 16,
    parameter int unsigned WIN_OPEN    = 4,
    parameter int unsigned CONV_CLKS   = 14,
    parameter int unsigned OVERHEAD    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             fs,
    input  logic             sclk,
    input  logic [RES_W-1:0] conv_result,
    output logic             sdo_data,
    output logic             sdo_oe,
    output logic             sample_win,
    output logic             conv_busy,
    output logic             conv_done,
    output logic             data_valid,
    output logic             pwr_down
);

    // Conversion clock is sclk/2, so each conversion clock spans two sclks
    localparam int unsigned CONV_SCLKS = 2 * CONV_CLKS + OVERHEAD;
    localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(3'b011);

    logic [PIN_CNT-1:0] pins_raw, pins_lvl, pins_prv;
    seq_evt_t           evt;
    logic [RES_W-1:0]   res_hold;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_CS]  = cs_n;
        pins_raw[PIN_FS]  = fs;
        pins_raw[PIN_SCK] = sclk;
    end

    adcf_sync #(
        .N       (PIN_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pins_raw),
        .lvl (pins_lvl),
        .prv (pins_prv)
    );

    adcf_frame_seq #(
        .FRAME_CLKS (FRAME_CLKS),
        .WIN_OPEN   (WIN_OPEN),
        .CONV_SCLKS (CONV_SCLKS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .lvl        (pins_lvl),
        .prv        (pins_prv),
        .evt        (evt),
        .sample_win (sample_win),
        .conv_busy  (conv_busy)
    );

    adcf_sdo_shift #(
        .FRAME_CLKS (FRAME_CLKS),
        .RES_W      (RES_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .res_hold  (res_hold),
        .res_valid (data_valid),
        .sdo_oe    (sdo_oe),
        .sdo_data  (sdo_data)
    );

    adcf_result_hold #(
        .RES_W (RES_W)
    ) u_hold (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .conv_result (conv_result),
        .res_hold    (res_hold),
        .res_valid   (data_valid),
        .conv_done   (conv_done),
        .pwr_down    (pwr_down)
    );

endmodule

// File: rtl/adc_serial_frame_chk.sv
module adc_serial_frame_chk (
    input logic clk,
    input logic rst,
    input logic sdo_oe,
    input logic sample_win,
    input logic conv_busy,
    input logic conv_done,
    input logic data_valid,
    input logic pwr_down
);

    p_win_busy_excl_r6: assert property (@(posedge clk) disable iff (rst)
        sample_win |-> !conv_busy);

    p_conv_after_win_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_busy) |-> $fell(sample_win));

    p_valid_on_done_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> (conv_done && !conv_busy));

    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!conv_busy && !sample_win));

    p_abort_sleep_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(data_valid) |-> pwr_down);

    p_wake_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> !pwr_down);

endmodule

bind adc_serial_frame adc_serial_frame_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sdo_oe     (sdo_oe),
    .sample_win (sample_win),
    .conv_busy  (conv_busy),
    .conv_done  (conv_done),
    .data_valid (data_valid),
    .pwr_down   (pwr_down)
);

// File: tb/adc_serial_frame_tb_top.sv
module adc_serial_frame_tb_top;

    localparam int H = 8;            // sys clocks per sclk half period
    localparam int NVEC = 6;
    // {fs_mode, abort, result}
    localparam logic [13:0] VEC [0:NVEC-1] = '{
        {1'b0, 1'b0, 12'hA5C},
        {1'b1, 1'b0, 12'h3F1},
        {1'b0, 1'b0, 12'hFFF},
        {1'b0, 1'b1, 12'h123},
        {1'b1, 1'b0, 12'h000},
        {1'b0, 1'b0, 12'h801}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, fs = 1'b1, sclk = 1'b0;
    logic [11:0] conv_in = '0;
    logic sdo_data, sdo_oe, sample_win, conv_busy, conv_done, data_valid, pwr_down;

    int  n_chk = 0, n_bad = 0;
    bit  fin = 1'b0;
    logic        mdl_valid = 1'b0;
    logic [11:0] mdl_res = '0;

    always #2 clk = ~clk;

    adc_serial_frame dut_i (
        .clk (clk), .rst (rst), .cs_n (cs_n), .fs (fs), .sclk (sclk),
        .conv_result (conv_in), .sdo_data (sdo_data), .sdo_oe (sdo_oe),
        .sample_win (sample_win), .conv_busy (conv_busy), .conv_done (conv_done),
        .data_valid (data_valid), .pwr_down (pwr_down)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            sclk = 1'b1; wait_sys(H);
            sclk = 1'b0; wait_sys(H);
        end
    endtask

    function automatic logic [15:0] exp_word();
        return mdl_valid ? {mdl_res, 4'h0} : 16'h0000;
    endfunction

    task automatic run_frame(input bit fsm, input logic [15:0] expw);
        logic [15:0] got;
        got = '0;
        if (fsm) begin
            fs = 1'b0; wait_sys(H);
            cs_n = 1'b0; wait_sys(H);
            chk("R3 cs fall with fs low no start", sdo_oe, 0);
            fs = 1'b1; wait_sys(H);
            fs = 1'b0; wait_sys(H);
            chk("R3 fs fall start oe", sdo_oe, 1);
        end else begin
            fs = 1'b1; wait_sys(H);
            cs_n = 1'b0; wait_sys(H);
            chk("R2 cs fall start oe", sdo_oe, 1);
        end
        chk("R2 first bit is D15", sdo_data, expw[15]);
        chk("R10 wake at start", pwr_down, 0);
        for (int n = 1; n <= 16; n++) begin
            sclk = 1'b1; wait_sys(H);
            got[16-n] = sdo_data;
            if (n == 4)  chk("R6 window closed clk4", sample_win, 0);
            if (n == 5)  chk("R6 window open clk5", sample_win, 1);
            if (n == 16) chk("R6 window open clk16", sample_win, 1);
            sclk = 1'b0; wait_sys(H);
        end
        chk("R4 R8 frame word", got, expw);
        chk("R7 busy after 16th fall", conv_busy, 1);
        chk("R6 window closed after 16th fall", sample_win, 0);
    endtask

    task automatic finish_conv();
        sclk = 1'b1; wait_sys(H);
        chk("R5 oe off at 17th rise", sdo_oe, 0);
        sclk = 1'b0; wait_sys(H);
        pulse(28);
        chk("R7 busy after 29 clocks", conv_busy, 1);
        chk("R7 not done after 29 clocks", conv_done, 0);
        pulse(1);
        chk("R7 busy cleared at 30", conv_busy, 0);
        chk("R7 done at 30", conv_done, 1);
        chk("R7 valid at 30", data_valid, 1);
        chk("R10 sleep at completion", pwr_down, 1);
        cs_n = 1'b1; wait_sys(H);
        chk("R9 cs rise after done keeps valid", data_valid, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_sys(5);
        rst = 1'b0;
        wait_sys(4);
        // R1 reset state
        chk("R1 oe", sdo_oe, 0);
        chk("R1 window", sample_win, 0);
        chk("R1 busy", conv_busy, 0);
        chk("R1 done", conv_done, 0);
        chk("R1 valid", data_valid, 0);
        chk("R1 pwr_down", pwr_down, 1);

        for (int i = 0; i < NVEC; i++) begin
            conv_in = VEC[i][11:0];
            run_frame(VEC[i][13], exp_word());
            if (VEC[i][12]) begin
                pulse(10);
                cs_n = 1'b1; wait_sys(H);
                chk("R9 abort busy", conv_busy, 0);
                chk("R9 abort valid", data_valid, 0);
                chk("R9 abort done", conv_done, 0);
                chk("R10 sleep on abort", pwr_down, 1);
                mdl_valid = 1'b0;
            end else begin
                finish_conv();
                mdl_valid = 1'b1;
                mdl_res = VEC[i][11:0];
            end
        end

        // R11: frame-sync strobe during conversion is ignored
        conv_in = 12'h5A6;
        run_frame(1'b1, exp_word());
        pulse(5);
        fs = 1'b1; wait_sys(H);
        fs = 1'b0; wait_sys(H);
        chk("R11 no restart oe", sdo_oe, 0);
        chk("R11 still busy", conv_busy, 1);
        pulse(25);
        chk("R11 completes on count", conv_done, 1);
        chk("R11 valid", data_valid, 1);
        cs_n = 1'b1; wait_sys(H);
        mdl_valid = 1'b1; mdl_res = 12'h5A6;

        // R9 / R5: chip select raised mid-frame
        fs = 1'b1; wait_sys(H);
        cs_n = 1'b0; wait_sys(H);
        pulse(8);
        cs_n = 1'b1; wait_sys(H);
        chk("R5 oe off at cs rise", sdo_oe, 0);
        chk("R9 mid-frame abort valid", data_valid, 0);
        chk("R9 mid-frame abort window", sample_win, 0);
        mdl_valid = 1'b0;

        // R8 / R9: next frame after abort carries zeros
        conv_in = 12'h0F0;
        run_frame(1'b0, exp_word());
        finish_conv();

        fin = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule